// File: doc/BRIEF.md
# Instruction prefix and mode decoder

This block sits at the front of an instruction decode pipe for a variable-length instruction set that runs in three execution modes (16-bit, 32-bit, 64-bit). Instruction bytes arrive one per cycle on a valid/ready handshake. The block absorbs prefix bytes until the first opcode byte arrives. It then issues a one-cycle report with the opcode byte, the resolved operand and address widths, the four bits of the width-extension prefix, the segment override in force, and a flag for one-byte opcodes that are not allowed in 64-bit mode.

The meaning of bytes 0x40..0x4F depends on the mode. In 64-bit mode they are width-extension prefixes; in the other two modes they are ordinary opcodes. A width-extension prefix only takes effect when it is the last prefix before the opcode. Runs of prefixes are bounded, and an over-long run is reported as an error. After every report the block drops all collected prefix state and starts the next instruction clean.

Top module: `ipfx_decoder`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. A byte is taken when `in_valid && in_ready`. A report (`out_valid`=1) appears in the cycle after the terminating byte is taken and lasts exactly one cycle. `in_ready` is 0 in that report cycle only.
- R2: In 16-bit mode (`mode`=0) the operand and address widths default to 16 bits. 0x66 selects a 32-bit operand width and 0x67 selects a 32-bit address width. Width codes are 0=16, 1=32 and 2=64 bits.
- R3: In 32-bit mode (`mode`=1) both widths default to 32 bits. 0x66 selects a 16-bit operand width and 0x67 selects a 16-bit address width.
- R4: In 64-bit mode (`mode`=2 or 3) the address width is 64 bits, or 32 bits with 0x67. It is never 16 bits.
- R5: In 64-bit mode the operand width is 32 bits by default and 16 bits with 0x66. It is 64 bits whenever the W bit of an active width-extension prefix is set, even when 0x66 is also present.
- R6: In 64-bit mode a byte 0x40..0x4F is a width-extension prefix, with bit 3 = W, bit 2 = R, bit 1 = X and bit 0 = B. In 16/32-bit mode the same byte ends prefix collection and is reported as the opcode, with all four extension bits 0.
- R7: A width-extension prefix counts only when no legacy prefix follows it. A later legacy prefix cancels it, and a later width-extension prefix replaces it.
- R8: Segment override codes on `out_seg` are: 0=none, 1=0x26, 2=0x2E, 3=0x36, 4=0x3E, 5=0x64, 6=0x65. The last override seen wins. In 64-bit mode 0x26/0x2E/0x36/0x3E are accepted as prefixes but leave the override unchanged.
- R9: In 64-bit mode `out_illegal` is 1 for opcodes 0x06, 0x07, 0x0E, 0x16, 0x17, 0x1E, 0x1F, 0x27, 0x2F, 0x37, 0x3F, 0x60, 0x61, 0x62, 0x82, 0x9A, 0xD4, 0xD5, 0xD6 and 0xEA. It is 0 for every opcode in 16/32-bit mode and for all other opcodes.
- R10: Up to 14 prefix bytes are accepted. If a 15th byte is also a prefix, the block reports immediately with `out_overlong`=1, `out_illegal`=0 and `out_opcode` equal to that byte.
- R11: After every report all prefix state (widths, extension bits, override, count) is cleared for the next instruction.
- R12: Bytes 0xF0, 0xF2 and 0xF3 are legacy prefixes. They count toward the limit and cancel a pending width-extension prefix, but change no reported field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be taken this cycle |
| in_byte | input | 8 | Instruction byte |
| mode | input | 2 | 0=16-bit, 1=32-bit, 2/3=64-bit |
| out_valid | output | 1 | One-cycle report strobe |
| out_opcode | output | 8 | Terminating byte |
| out_opsize | output | 2 | Operand width code |
| out_adsize | output | 2 | Address width code |
| out_ext_w | output | 1 | Extension W bit |
| out_ext_r | output | 1 | Extension R bit |
| out_ext_x | output | 1 | Extension X bit |
| out_ext_b | output | 1 | Extension B bit |
| out_seg | output | 3 | Segment override code |
| out_illegal | output | 1 | Opcode not allowed in 64-bit mode |
| out_overlong | output | 1 | Prefix run exceeded the limit |

## Verification
Two functions can decide the same instruction. Operand-width resolution has to settle a conflict between 0x66 and an extension W bit. Extension cancellation is also live, so the bench sends 0x66 followed by a W prefix, which must give 64 bits, and a W prefix followed by 0x66, which must give 16 bits with cleared extension bits. The prefix limit and prefix classification also meet on one byte. The bench sends fourteen prefixes and then an opcode, which must give a normal report. It then sends fifteen prefixes, and the 15th byte must produce the overlong report while the next instruction shows fully cleared state.

// File: rtl/ipfx_pkg.sv
package ipfx_pkg;

  localparam logic [1:0] SZ16 = 2'd0;
  localparam logic [1:0] SZ32 = 2'd1;
  localparam logic [1:0] SZ64 = 2'd2;

  // mode code 2 or 3 means 64-bit
  function automatic logic is_wide(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic is_legacy(input logic [7:0] b);
    case (b)
      8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
      8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // {hit, code}; in wide mode the four old segment bytes do not hit
  function automatic logic [3:0] seg_of(input logic [7:0] b, input logic wide);
    case (b)
      8'h26: return wide ? 4'h0 : 4'h9;
      8'h2E: return wide ? 4'h0 : 4'hA;
      8'h36: return wide ? 4'h0 : 4'hB;
      8'h3E: return wide ? 4'h0 : 4'hC;
      8'h64: return 4'hD;
      8'h65: return 4'hE;
      default: return 4'h0;
    endcase
  endfunction

  function automatic logic [1:0] op_size(input logic [1:0] m, input logic p66, input logic w);
    if (is_wide(m)) return w ? SZ64 : (p66 ? SZ16 : SZ32);
    if (m == 2'd1)  return p66 ? SZ16 : SZ32;
    return p66 ? SZ32 : SZ16;
  endfunction

  function automatic logic [1:0] ad_size(input logic [1:0] m, input logic p67);
    if (is_wide(m)) return p67 ? SZ32 : SZ64;
    if (m == 2'd1)  return p67 ? SZ16 : SZ32;
    return p67 ? SZ32 : SZ16;
  endfunction

  function automatic logic banned_wide(input logic [7:0] op);
    case (op)
      8'h06, 8'h07, 8'h0E, 8'h16, 8'h17, 8'h1E, 8'h1F,
      8'h27, 8'h2F, 8'h37, 8'h3F, 8'h60, 8'h61, 8'h62,
      8'h82, 8'h9A, 8'hD4, 8'hD5, 8'hD6, 8'hEA: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ipfx_classify.sv
module ipfx_classify
  import ipfx_pkg::*;
(
  input  logic [7:0] byte_i,
  input  logic [1:0] mode_i,
  output logic       legacy_o,
  output logic       ext_o,
  output logic       p66_o,
  output logic       p67_o,
  output logic       seg_hit_o,
  output logic [2:0] seg_code_o
);
  logic [3:0] seg_w;

  always_comb begin
    seg_w      = seg_of(byte_i, is_wide(mode_i));
    legacy_o   = is_legacy(byte_i);
    ext_o      = is_wide(mode_i) && (byte_i[7:4] == 4'h4);
    p66_o      = (byte_i == 8'h66);
    p67_o      = (byte_i == 8'h67);
    seg_hit_o  = seg_w[3];
    seg_code_o = seg_w[2:0] - 3'd0;
  end
endmodule

// File: rtl/ipfx_collect.sv
module ipfx_collect #(
  parameter int MAX_PREFIX = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take_i,
  input  logic       clear_i,
  input  logic       ext_i,
  input  logic [3:0] ext_bits_i,
  input  logic       p66_i,
  input  logic       p67_i,
  input  logic       seg_hit_i,
  input  logic [2:0] seg_code_i,
  output logic       p66_o,
  output logic       p67_o,
  output logic       ext_v_o,
  output logic [3:0] ext_bits_o,
  output logic [2:0] seg_o,
  output logic       limit_o
);
  localparam int CW = $clog2(MAX_PREFIX + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_PREFIX);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      cnt        <= '0;
      p66_o      <= 1'b0;
      p67_o      <= 1'b0;
      ext_v_o    <= 1'b0;
      ext_bits_o <= '0;
      seg_o      <= '0;
    end else if (take_i) begin
      cnt <= cnt + 1'b1;
      if (ext_i) begin
        ext_v_o    <= 1'b1;
        ext_bits_o <= ext_bits_i;
      end else begin
        ext_v_o    <= 1'b0;
        ext_bits_o <= '0;
        if (p66_i)     p66_o <= 1'b1;
        if (p67_i)     p67_o <= 1'b1;
        if (seg_hit_i) seg_o <= seg_code_i;
      end
    end
  end

  assign limit_o = (cnt == LIMIT);
endmodule

// File: rtl/ipfx_resolve.sv
module ipfx_resolve
  import ipfx_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic [7:0] opcode_i,
  input  logic       p66_i,
  input  logic       p67_i,
  input  logic       ext_v_i,
  input  logic [3:0] ext_bits_i,
  input  logic       overlong_i,
  output logic [1:0] opsize_o,
  output logic [1:0] adsize_o,
  output logic [3:0] ext_o,
  output logic       illegal_o
);
  logic w_eff;

  always_comb begin
    ext_o     = ext_v_i ? ext_bits_i : 4'h0;
    w_eff     = ext_o[3];
    opsize_o  = op_size(mode_i, p66_i, w_eff);
    adsize_o  = ad_size(mode_i, p67_i);
    illegal_o = !overlong_i && is_wide(mode_i) && banned_wide(opcode_i);
  end
endmodule

// File: rtl/ipfx_decoder.sv
module ipfx_decoder #(
  parameter int MAX_PREFIX = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_byte,
  input  logic [1:0] mode,
  output logic       out_valid,
  output logic [7:0] out_opcode,
  output logic [1:0] out_opsize,
  output logic [1:0] out_adsize,
  output logic       out_ext_w,
  output logic       out_ext_r,
  output logic       out_ext_x,
  output logic       out_ext_b,
  output logic [2:0] out_seg,
  output logic       out_illegal,
  output logic       out_overlong
);
  // named internal events
  logic       acc_fire, is_prefix, take_pfx, op_fire, overlong_now;
  logic       c_legacy, c_ext, c_p66, c_p67, c_seg_hit;
  logic [2:0] c_seg;
  logic       h_p66, h_p67, h_ext_v, limit_hit;
  logic [3:0] h_ext;
  logic [2:0] h_seg;
  logic [1:0] r_op, r_ad;
  logic [3:0] r_ext;
  logic       r_ill;

  assign in_ready     = !out_valid;
  assign acc_fire     = in_valid && in_ready;
  assign is_prefix    = c_legacy || c_ext;
  assign overlong_now = is_prefix && limit_hit;
  assign take_pfx     = acc_fire && is_prefix && !limit_hit;
  assign op_fire      = acc_fire && (!is_prefix || limit_hit);

  ipfx_classify u_cls (
    .byte_i(in_byte), .mode_i(mode),
    .legacy_o(c_legacy), .ext_o(c_ext), .p66_o(c_p66), .p67_o(c_p67),
    .seg_hit_o(c_seg_hit), .seg_code_o(c_seg)
  );

  ipfx_collect #(.MAX_PREFIX(MAX_PREFIX)) u_col (
    .clk(clk), .rst_n(rst_n), .take_i(take_pfx), .clear_i(op_fire),
    .ext_i(c_ext), .ext_bits_i(in_byte[3:0]), .p66_i(c_p66), .p67_i(c_p67),
    .seg_hit_i(c_seg_hit), .seg_code_i(c_seg),
    .p66_o(h_p66), .p67_o(h_p67), .ext_v_o(h_ext_v), .ext_bits_o(h_ext),
    .seg_o(h_seg), .limit_o(limit_hit)
  );

  ipfx_resolve u_res (
    .mode_i(mode), .opcode_i(in_byte), .p66_i(h_p66), .p67_i(h_p67),
    .ext_v_i(h_ext_v), .ext_bits_i(h_ext), .overlong_i(overlong_now),
    .opsize_o(r_op), .adsize_o(r_ad), .ext_o(r_ext), .illegal_o(r_ill)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_opcode   <= '0;
      out_opsize   <= '0;
      out_adsize   <= '0;
      {out_ext_w, out_ext_r, out_ext_x, out_ext_b} <= '0;
      out_seg      <= '0;
      out_illegal  <= 1'b0;
      out_overlong <= 1'b0;
    end else begin
      out_valid <= op_fire;
      if (op_fire) begin
        out_opcode   <= in_byte;
        out_opsize   <= r_op;
        out_adsize   <= r_ad;
        {out_ext_w, out_ext_r, out_ext_x, out_ext_b} <= r_ext;
        out_seg      <= h_seg;
        out_illegal  <= r_ill;
        out_overlong <= overlong_now;
      end
    end
  end
endmodule

// File: rtl/ipfx_decoder_checker.sv
module ipfx_decoder_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       in_ready,
  input logic       op_fire,
  input logic       take_pfx,
  input logic       out_valid,
  input logic [1:0] out_opsize,
  input logic [1:0] out_adsize,
  input logic       out_ext_w,
  input logic       out_ext_r,
  input logic       out_ext_x,
  input logic       out_ext_b,
  input logic       out_illegal,
  input logic       out_overlong
);
  // R1: report follows the terminating byte
  p_report_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire |=> out_valid);
  // R1: report lasts one cycle and blocks input
  p_single_report_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_ready_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  // R4: no 16-bit address in wide mode
  p_no_narrow_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode[1])) |-> (out_adsize != 2'd0));
  // R5: W forces 64-bit operand
  p_w_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ext_w) |-> (out_opsize == 2'd2));
  // R6: no extension bits outside wide mode
  p_no_ext_narrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(mode[1])) |-> !(out_ext_w || out_ext_r || out_ext_x || out_ext_b));
  // R9: illegal only in wide mode
  p_illegal_wide_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> $past(mode[1]));
  // R10: overlong and illegal are exclusive
  p_overlong_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_overlong) |-> !out_illegal);
  // R11: no prefix taken while reporting
  p_no_take_in_report_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(take_pfx || op_fire));
endmodule

bind ipfx_decoder ipfx_decoder_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .in_ready(in_ready),
  .op_fire(op_fire), .take_pfx(take_pfx), .out_valid(out_valid),
  .out_opsize(out_opsize), .out_adsize(out_adsize),
  .out_ext_w(out_ext_w), .out_ext_r(out_ext_r), .out_ext_x(out_ext_x),
  .out_ext_b(out_ext_b), .out_illegal(out_illegal), .out_overlong(out_overlong)
);

// File: tb/ipfx_decoder_test.sv
module ipfx_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic [1:0] mode = 2'd1;
  logic       in_ready, out_valid, out_ext_w, out_ext_r, out_ext_x, out_ext_b;
  logic       out_illegal, out_overlong;
  logic [7:0] out_opcode;
  logic [1:0] out_opsize, out_adsize;
  logic [2:0] out_seg;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0] bq [0:15];
  int         bn = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipfx_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .mode(mode), .out_valid(out_valid),
    .out_opcode(out_opcode), .out_opsize(out_opsize), .out_adsize(out_adsize),
    .out_ext_w(out_ext_w), .out_ext_r(out_ext_r), .out_ext_x(out_ext_x),
    .out_ext_b(out_ext_b), .out_seg(out_seg), .out_illegal(out_illegal),
    .out_overlong(out_overlong)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    bq[bn] = b;
    bn++;
  endtask

  // drives queued bytes back to back; returns at the negedge of the report cycle
  task automatic issue(input logic [1:0] m);
    for (int i = 0; i < bn; i++) begin
      @(negedge clk);
      mode = m; in_valid = 1'b1; in_byte = bq[i];
    end
    @(negedge clk);
    in_valid = 1'b0;
    bn = 0;
  endtask

  // checks a report, then that it ends and input reopens
  task automatic expect_rep(input string req, input int opc, input int ops, input int ads,
                            input int wrxb, input int seg, input int ill, input int ovl);
    chk({req, " valid"}, out_valid, 1);
    chk({req, " ready low (R1)"}, in_ready, 0);
    chk({req, " opcode"}, out_opcode, opc);
    chk({req, " opsize"}, out_opsize, ops);
    chk({req, " adsize"}, out_adsize, ads);
    chk({req, " ext"}, {out_ext_w, out_ext_r, out_ext_x, out_ext_b}, wrxb);
    chk({req, " seg"}, out_seg, seg);
    chk({req, " illegal"}, out_illegal, ill);
    chk({req, " overlong"}, out_overlong, ovl);
    @(negedge clk);
    chk({req, " single pulse (R1)"}, out_valid, 0);
    chk({req, " ready back (R1)"}, in_ready, 1);
  endtask

  task automatic t_reset_r1;
    chk("R1 reset valid", out_valid, 0);
    chk("R1 reset ready", in_ready, 1);
  endtask

  task automatic t_mode16_r2;
    push(8'h90); issue(2'd0);
    expect_rep("R2 default", 8'h90, 0, 0, 0, 0, 0, 0);
    push(8'h66); push(8'h67); push(8'h90); issue(2'd0);
    expect_rep("R2 both prefixes", 8'h90, 1, 1, 0, 0, 0, 0);
  endtask

  task automatic t_mode32_r3;
    push(8'h90); issue(2'd1);
    expect_rep("R3 default", 8'h90, 1, 1, 0, 0, 0, 0);
    push(8'h67); push(8'h66); push(8'h90); issue(2'd1);
    expect_rep("R3 both prefixes", 8'h90, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_mode64_r4_r5;
    push(8'h90); issue(2'd2);
    expect_rep("R4 default", 8'h90, 1, 2, 0, 0, 0, 0);
    push(8'h67); push(8'h90); issue(2'd3);
    expect_rep("R4 addr32", 8'h90, 1, 1, 0, 0, 0, 0);
    push(8'h66); push(8'h90); issue(2'd2);
    expect_rep("R5 op16", 8'h90, 0, 2, 0, 0, 0, 0);
    push(8'h48); push(8'h90); issue(2'd2);
    expect_rep("R5 W op64", 8'h90, 2, 2, 8, 0, 0, 0);
    push(8'h66); push(8'h48); push(8'h90); issue(2'd2);
    expect_rep("R5 W over 0x66", 8'h90, 2, 2, 8, 0, 0, 0);
  endtask

  task automatic t_ext_r6;
    push(8'h4F); push(8'h01); issue(2'd2);
    expect_rep("R6 all ext bits", 8'h01, 2, 2, 15, 0, 0, 0);
    push(8'h45); push(8'h01); issue(2'd2);
    expect_rep("R6 R and B", 8'h01, 1, 2, 5, 0, 0, 0);
    push(8'h66); push(8'h41); issue(2'd1);
    expect_rep("R6 0x41 opcode in 32", 8'h41, 0, 1, 0, 0, 0, 0);
    push(8'h4A); issue(2'd0);
    expect_rep("R6 0x4A opcode in 16", 8'h4A, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_cancel_r7;
    push(8'h48); push(8'h66); push(8'h90); issue(2'd2);
    expect_rep("R7 legacy cancels", 8'h90, 0, 2, 0, 0, 0, 0);
    push(8'h41); push(8'h4A); push(8'h90); issue(2'd2);
    expect_rep("R7 later ext replaces", 8'h90, 2, 2, 10, 0, 0, 0);
  endtask

  task automatic t_seg_r8;
    push(8'h26); push(8'h64); push(8'h90); issue(2'd1);
    expect_rep("R8 last wins 0x64", 8'h90, 1, 1, 0, 5, 0, 0);
    push(8'h64); push(8'h2E); push(8'h90); issue(2'd0);
    expect_rep("R8 last wins 0x2E", 8'h90, 0, 0, 0, 2, 0, 0);
    push(8'h36); push(8'h3E); push(8'h90); issue(2'd1);
    expect_rep("R8 0x3E in 32", 8'h90, 1, 1, 0, 4, 0, 0);
    push(8'h65); push(8'h26); push(8'h90); issue(2'd2);
    expect_rep("R8 0x26 no-op in 64", 8'h90, 1, 2, 0, 6, 0, 0);
    push(8'h2E); push(8'h36); push(8'h90); issue(2'd2);
    expect_rep("R8 old segs none in 64", 8'h90, 1, 2, 0, 0, 0, 0);
  endtask

  task automatic t_illegal_r9;
    logic [7:0] bad [0:19];
    bad = '{8'h06, 8'h07, 8'h0E, 8'h16, 8'h17, 8'h1E, 8'h1F, 8'h27, 8'h2F, 8'h37,
            8'h3F, 8'h60, 8'h61, 8'h62, 8'h82, 8'h9A, 8'hD4, 8'hD5, 8'hD6, 8'hEA};
    for (int i = 0; i < 20; i++) begin
      push(bad[i]); issue(2'd2);
      expect_rep($sformatf("R9 banned %02h in 64", bad[i]), bad[i], 1, 2, 0, 0, 1, 0);
    end
    push(8'h82); issue(2'd1);
    expect_rep("R9 0x82 legal in 32", 8'h82, 1, 1, 0, 0, 0, 0);
    push(8'h27); issue(2'd0);
    expect_rep("R9 0x27 legal in 16", 8'h27, 0, 0, 0, 0, 0, 0);
    push(8'h80); issue(2'd2);
    expect_rep("R9 0x80 legal in 64", 8'h80, 1, 2, 0, 0, 0, 0);
  endtask

  task automatic t_limit_r10_r11;
    for (int i = 0; i < 13; i++) push(8'h66);
    push(8'h67); push(8'h90); issue(2'd1);
    expect_rep("R10 fourteen prefixes ok", 8'h90, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 14; i++) push(8'hF3);
    push(8'h48); issue(2'd2);
    expect_rep("R10 fifteenth prefix overlong", 8'h48, 1, 2, 0, 0, 0, 1);
    for (int i = 0; i < 14; i++) push(8'h64);
    push(8'h66); issue(2'd1);
    expect_rep("R10 fifteenth legacy overlong", 8'h66, 1, 1, 0, 5, 0, 1);
    push(8'h90); issue(2'd1);
    expect_rep("R11 clean after overlong", 8'h90, 1, 1, 0, 0, 0, 0);
  endtask

  task automatic t_rep_lock_r12;
    push(8'h4C); push(8'hF0); push(8'hF2); push(8'h01); issue(2'd2);
    expect_rep("R12 F0/F2 cancel ext only", 8'h01, 1, 2, 0, 0, 0, 0);
    push(8'hF3); push(8'h90); issue(2'd0);
    expect_rep("R12 F3 no field", 8'h90, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_gaps_r1_r11;
    @(negedge clk); mode = 2'd1; in_valid = 1'b1; in_byte = 8'h66;
    @(negedge clk); in_valid = 1'b0; in_byte = 8'h90;
    @(negedge clk);
    chk("R1 idle gap no report", out_valid, 0);
    @(negedge clk); in_valid = 1'b1; in_byte = 8'h90;
    @(negedge clk); in_valid = 1'b0;
    expect_rep("R1 prefix kept over gap", 8'h90, 0, 1, 0, 0, 0, 0);
    push(8'h90); issue(2'd1);
    expect_rep("R11 prefix cleared", 8'h90, 1, 1, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_mode16_r2();
    t_mode32_r3();
    t_mode64_r4_r5();
    t_ext_r6();
    t_cancel_r7();
    t_seg_r8();
    t_illegal_r9();
    t_limit_r10_r11();
    t_rep_lock_r12();
    t_gaps_r1_r11();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule